// File: doc/BRIEF.md
# Two-Group DMA Channel Chaining Trigger

This block lets one DMA channel start another without software help. Every channel has a configuration word that gives it a role: it can stay out of chaining, or it can act as the source or the destination of one of two chaining groups. Each channel reports completion at four levels: fragment, block, transaction and link-list. When the source channel of a group reaches the completion level programmed on it, the block sends a start pulse to that group's destination channel.

The block only sees completion pulses coming in and start pulses going out. It does not move data, generate addresses or decode a register bus. The configuration words arrive as a flat bus, one 32-bit word per channel. Two groups operate side by side and do not affect each other. A group that is missing its source or its destination stays silent. When several channels claim the same role, the lowest-numbered channel holds that role.

Top module: `chain_trigger`

## Requirements
- R1: Bits [31:24] of a channel's configuration word hold its role: 0 = unchained, 1 = source of group 0, 2 = source of group 1, 3 = destination of group 0, 4 = destination of group 1.
- R2: Bits [23:16] of a configuration word select the trigger level: 1 = fragment done, 2 = block done, 3 = transaction done, 4 = link-list done. Bits [15:0] (request mode in [15:8], interrupt type in [7:0]) have no effect on start pulses.
- R3: When a group's source channel signals its selected completion level in cycle N, the group's destination channel sees `start_o` high in cycle N+1 only. The pulse is registered and lasts one clock.
- R4: A group uses the trigger level programmed on its source channel. The trigger field of the destination channel is ignored.
- R5: A trigger level of 0, or of 5 or more, on a source channel never produces a start pulse.
- R6: A channel whose role is 0, or 5 or more, never receives a start pulse, and its completion pulses never cause one.
- R7: A group with no channel in its source role, or no channel in its destination role, produces no start pulses.
- R8: When more than one channel claims the same role, only the lowest-numbered claimant holds it. The other claimants neither trigger nor receive starts.
- R9: The two groups work independently, and both can issue a start pulse in the same cycle.
- R10: While `rst` is high, and in the first cycle after it is sampled high, `start_o` is all zero.
- R11: Completion pulses at a level other than the selected one do not cause a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_words | input | NUM_CH*32 | Configuration word per channel; channel k uses bits [32k+31:32k] |
| frag_done_i | input | NUM_CH | Fragment-complete pulse per channel |
| blk_done_i | input | NUM_CH | Block-complete pulse per channel |
| xfer_done_i | input | NUM_CH | Transaction-complete pulse per channel |
| list_done_i | input | NUM_CH | Link-list-complete pulse per channel |
| start_o | output | NUM_CH | Registered start pulse per channel |

## Verification
The bench targets role conflicts. When two channels claim the same source role, or the same destination role, a design that picks the highest-numbered claimant, or that ORs all claimants together, will start the wrong channel or start extra channels. Trigger levels are tested across the whole field range, so treating values of 5 and above as a real level, or ignoring a level of zero, shows up as a stray start. The bench also drives completion pulses at levels that were not selected and writes noise into the low configuration bits, so a design that decodes those bits, or that reads the trigger field from the destination channel, produces starts that the model does not expect. Both groups are fired in the same cycle, and a long randomized run is compared every clock. This catches pulses that come a cycle early or late, and groups that interfere with each other.

// File: rtl/chain_pkg.sv
package chain_pkg;

  localparam int CFG_W    = 32;
  localparam int FIELD_W  = 8;
  localparam int ROLE_LSB = 24;
  localparam int TRIG_LSB = 16;
  localparam int NUM_GRP  = 2;
  localparam int LVL_N    = 4;

  typedef enum logic [FIELD_W-1:0] {
    ROLE_NONE   = 8'd0,
    ROLE_SRC_G0 = 8'd1,
    ROLE_SRC_G1 = 8'd2,
    ROLE_DST_G0 = 8'd3,
    ROLE_DST_G1 = 8'd4
  } role_e;

  typedef enum logic [FIELD_W-1:0] {
    TRIG_OFF  = 8'd0,
    TRIG_FRAG = 8'd1,
    TRIG_BLK  = 8'd2,
    TRIG_XFER = 8'd3,
    TRIG_LIST = 8'd4
  } trig_e;

  // one-hot level select: bit0 fragment, bit1 block, bit2 transaction, bit3 list
  function automatic logic [LVL_N-1:0] trig_to_lvl(input logic [FIELD_W-1:0] t);
    logic [LVL_N-1:0] v;
    case (t)
      TRIG_FRAG: v = 4'b0001;
      TRIG_BLK:  v = 4'b0010;
      TRIG_XFER: v = 4'b0100;
      TRIG_LIST: v = 4'b1000;
      default:   v = 4'b0000;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/chain_cfg_decode.sv
module chain_cfg_decode
  import chain_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH*CFG_W-1:0]             cfg_words,
  output logic [NUM_GRP-1:0][NUM_CH-1:0]      src_claim,
  output logic [NUM_GRP-1:0][NUM_CH-1:0]      dst_claim,
  output logic [NUM_CH-1:0][LVL_N-1:0]        lvl_sel
);

  localparam int LOW_W = TRIG_LSB;

  logic [NUM_CH-1:0][LOW_W-1:0] cfg_unused_bits;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [FIELD_W-1:0] role;
    logic [FIELD_W-1:0] trig;
    assign role = cfg_words[ch*CFG_W+ROLE_LSB +: FIELD_W];
    assign trig = cfg_words[ch*CFG_W+TRIG_LSB +: FIELD_W];
    assign cfg_unused_bits[ch] = cfg_words[ch*CFG_W +: LOW_W];
    assign lvl_sel[ch] = trig_to_lvl(trig);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
      localparam logic [FIELD_W-1:0] SRC_CODE = FIELD_W'(ROLE_SRC_G0) + FIELD_W'(g);
      localparam logic [FIELD_W-1:0] DST_CODE = FIELD_W'(ROLE_DST_G0) + FIELD_W'(g);
      assign src_claim[g][ch] = (role == SRC_CODE);
      assign dst_claim[g][ch] = (role == DST_CODE);
    end
  end

endmodule

// File: rtl/chain_slot_pick.sv
module chain_slot_pick #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] claim,
  output logic [NUM_CH-1:0] grant
);

  localparam logic [NUM_CH-1:0] ONE = {{(NUM_CH-1){1'b0}}, 1'b1};

  // isolate lowest set bit: lowest-numbered claimant holds the slot
  assign grant = claim & (~claim + ONE);

endmodule

// File: rtl/chain_group_fire.sv
module chain_group_fire #(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_CH-1:0] src_grant,
  input  logic [NUM_CH-1:0] dst_grant,
  input  logic [NUM_CH-1:0] sel_done,
  output logic [NUM_CH-1:0] fire
);

  logic src_event;

  assign src_event = |(src_grant & sel_done);
  assign fire      = src_event ? dst_grant : '0;

endmodule

// File: rtl/chain_trigger.sv
module chain_trigger
  import chain_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*CFG_W-1:0] cfg_words,
  input  logic [NUM_CH-1:0]       frag_done_i,
  input  logic [NUM_CH-1:0]       blk_done_i,
  input  logic [NUM_CH-1:0]       xfer_done_i,
  input  logic [NUM_CH-1:0]       list_done_i,
  output logic [NUM_CH-1:0]       start_o
);

  logic [NUM_GRP-1:0][NUM_CH-1:0] src_claim;
  logic [NUM_GRP-1:0][NUM_CH-1:0] dst_claim;
  logic [NUM_CH-1:0][LVL_N-1:0]   lvl_sel;
  logic [NUM_CH-1:0]              sel_done;
  logic [NUM_GRP-1:0][NUM_CH-1:0] fire;
  logic [NUM_CH-1:0]              start_d;

  chain_cfg_decode #(.NUM_CH(NUM_CH)) u_decode (
    .cfg_words (cfg_words),
    .src_claim (src_claim),
    .dst_claim (dst_claim),
    .lvl_sel   (lvl_sel)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_sel
    assign sel_done[ch] = |(lvl_sel[ch] &
                            {list_done_i[ch], xfer_done_i[ch], blk_done_i[ch], frag_done_i[ch]});
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_group
    logic [NUM_CH-1:0] src_grant;
    logic [NUM_CH-1:0] dst_grant;

    chain_slot_pick #(.NUM_CH(NUM_CH)) u_src_pick (
      .claim (src_claim[g]),
      .grant (src_grant)
    );

    chain_slot_pick #(.NUM_CH(NUM_CH)) u_dst_pick (
      .claim (dst_claim[g]),
      .grant (dst_grant)
    );

    chain_group_fire #(.NUM_CH(NUM_CH)) u_fire (
      .src_grant (src_grant),
      .dst_grant (dst_grant),
      .sel_done  (sel_done),
      .fire      (fire[g])
    );
  end

  always_comb begin
    start_d = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      start_d = start_d | fire[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) start_o <= '0;
    else     start_o <= start_d;
  end

  // R10
  rst_quiet_chk: assert property (@(posedge clk) rst |=> (start_o == '0));

  // R9
  two_groups_max_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(start_o) <= NUM_GRP);

  // R3
  start_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start_o != '0) |-> $past(|(frag_done_i | blk_done_i | xfer_done_i | list_done_i)));

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chk
    // R6
    start_only_dst_chk: assert property (@(posedge clk) disable iff (rst)
      start_o[ch] |-> ($past(cfg_words[ch*CFG_W+ROLE_LSB +: FIELD_W]) inside {8'd3, 8'd4}));
  end

endmodule

// File: tb/chain_trigger_bench.sv
module chain_trigger_bench;

  localparam int N = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] cfg [N];
  logic [N-1:0] frag = '0, blk = '0, xfer = '0, lst = '0;
  logic [N*32-1:0] cfg_bus;
  logic [N-1:0] start_o;

  int compared   = 0;
  int mismatched = 0;
  bit done_flag  = 0;

  always #4 clk = ~clk;

  always_comb begin
    for (int c = 0; c < N; c++) cfg_bus[c*32 +: 32] = cfg[c];
  end

  chain_trigger #(.NUM_CH(N)) u_chain_trigger (
    .clk         (clk),
    .rst         (rst),
    .cfg_words   (cfg_bus),
    .frag_done_i (frag),
    .blk_done_i  (blk),
    .xfer_done_i (xfer),
    .list_done_i (lst),
    .start_o     (start_o)
  );

  function automatic logic [N-1:0] model();
    logic [N-1:0] r = '0;
    for (int g = 0; g < 2; g++) begin
      int s = -1;
      int d = -1;
      for (int c = 0; c < N; c++) begin
        if (cfg[c][31:24] == 8'(1 + g) && s < 0) s = c;
        if (cfg[c][31:24] == 8'(3 + g) && d < 0) d = c;
      end
      if (s >= 0 && d >= 0) begin
        int t = int'(cfg[s][23:16]);
        bit hit = (t == 1 && frag[s]) || (t == 2 && blk[s]) ||
                  (t == 3 && xfer[s]) || (t == 4 && lst[s]);
        if (hit) r[d] = 1'b1;
      end
    end
    return r;
  endfunction

  // one clock: expectation from inputs held now, compared after the edge
  task automatic step(input string tag);
    logic [N-1:0] exp_v;
    exp_v = rst ? '0 : model();
    @(posedge clk);
    #2;
    compared++;
    if (start_o !== exp_v) begin
      mismatched++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, start_o, exp_v, $time);
    end
  endtask

  task automatic set_cfg(input int ch, input int role, input int trig);
    cfg[ch] = {8'(role), 8'(trig), 16'($urandom)};
  endtask

  task automatic clear_all();
    for (int c = 0; c < N; c++) cfg[c] = 32'h0;
    frag = '0; blk = '0; xfer = '0; lst = '0;
  endtask

  task automatic pulse(input string tag, input int ch, input int lvl);
    frag = '0; blk = '0; xfer = '0; lst = '0;
    case (lvl)
      1: frag[ch] = 1'b1;
      2: blk[ch]  = 1'b1;
      3: xfer[ch] = 1'b1;
      default: lst[ch] = 1'b1;
    endcase
    step(tag);
    frag = '0; blk = '0; xfer = '0; lst = '0;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      mismatched++;
      $display("FAIL watchdog R3 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    clear_all();
    // R10: active chain and pulses during reset give no start
    set_cfg(0, 1, 1); set_cfg(1, 3, 0);
    frag = '1; blk = '1; xfer = '1; lst = '1;
    #2;
    repeat (3) step("R10");
    rst = 1'b0;
    step("R10");
    clear_all();
    step("R10");

    // R1 R3: group 0, fragment level
    set_cfg(1, 1, 1); set_cfg(5, 3, 0);
    pulse("R3", 1, 1);
    pulse("R1", 1, 1);
    // R11: other levels ignored
    pulse("R11", 1, 2);
    pulse("R11", 1, 3);
    pulse("R11", 1, 4);
    // R2: every level selected in turn, low bits noisy
    for (int t = 1; t <= 4; t++) begin
      set_cfg(1, 1, t);
      for (int l = 1; l <= 4; l++) pulse("R2", 1, l);
    end
    // R4: destination trigger field ignored
    set_cfg(1, 1, 0); set_cfg(5, 3, 1);
    pulse("R4", 1, 1);
    pulse("R4", 5, 1);
    set_cfg(1, 1, 3); set_cfg(5, 3, 1);
    pulse("R4", 1, 3);
    pulse("R4", 1, 1);
    // R5: out-of-range trigger levels
    for (int t = 5; t <= 9; t++) begin
      set_cfg(1, 1, t);
      for (int l = 1; l <= 4; l++) pulse("R5", 1, l);
    end
    set_cfg(1, 1, 255);
    pulse("R5", 1, 4);

    // R6: unchained and invalid roles
    clear_all();
    set_cfg(2, 0, 1); set_cfg(3, 5, 1); set_cfg(4, 200, 2);
    set_cfg(6, 3, 1);
    pulse("R6", 2, 1);
    pulse("R6", 3, 1);
    pulse("R6", 4, 2);
    // R7: destination missing, then source missing
    clear_all();
    set_cfg(0, 2, 1);
    pulse("R7", 0, 1);
    clear_all();
    set_cfg(7, 4, 1);
    pulse("R7", 7, 1);

    // R8: duplicate claims, lowest wins
    clear_all();
    set_cfg(2, 1, 2); set_cfg(6, 1, 2);
    set_cfg(3, 3, 0); set_cfg(4, 3, 0);
    pulse("R8", 6, 2);
    pulse("R8", 2, 2);

    // R9: both groups fire in the same cycle
    clear_all();
    set_cfg(0, 1, 1); set_cfg(7, 3, 0);
    set_cfg(2, 2, 4); set_cfg(5, 4, 0);
    frag[0] = 1'b1; lst[2] = 1'b1;
    step("R9");
    frag = '0; lst = '0;
    step("R9");
    pulse("R9", 2, 4);

    // randomized run, compared every clock
    for (int k = 0; k < 3000; k++) begin
      if (k % 40 == 0) begin
        for (int c = 0; c < N; c++) begin
          int r = $urandom_range(0, 9);
          set_cfg(c, r > 6 ? 0 : r, $urandom_range(0, 6));
        end
      end
      frag = N'($urandom) & N'($urandom);
      blk  = N'($urandom) & N'($urandom);
      xfer = N'($urandom) & N'($urandom);
      lst  = N'($urandom) & N'($urandom);
      step("R3");
    end

    done_flag = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule